// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the digital timing controller for a static RAM that shadows every bit in a nonvolatile backup array. A mode input chooses between plain RAM use and transfer mode. In transfer mode, a rising edge on a start input launches one of two sequences. A direction input picks which one. A STORE copies the RAM into the backup array. A RECALL loads the backup contents back into the RAM.

The block drives three gate lines. Each line carries a 2-bit level code that selects zero, the supply, or the internal high voltage. The block also drives an enable for the high-voltage pump and a control for the array supply: high means drive toward the supply, low means pull the array toward ground. A STORE runs two timed steps. The first step erases the whole backup array. The second step programs each backup cell that its RAM cell selects. A short all-zero gap separates the two steps, so the erase line reaches zero before the program line goes to high voltage. A RECALL holds all gate lines at the supply level while the array supply ramps down, rests at ground and ramps up again.

Every interval is a count of clock cycles derived from a clock-frequency parameter and a duration parameter. The block reports busy for the whole sequence and gives a one-clock done pulse at the end. It also reports whether ordinary RAM access is allowed.

Top module: `nvxfer_top`

## Requirements
- R1: After reset all three gate lines carry code 00 (zero), pumpEn and done are 0, supplyRamp is 1 and busy is 0.
- R2: A sequence starts only on a rising edge of startPulse seen at a clock edge while nvMode is 1 and busy is 0. recallSel=0 selects STORE and recallSel=1 selects RECALL. The first phase shows on the outputs in the cycle after that edge. A start level held high does not restart a sequence.
- R3: The STORE erase step lasts STORE_US*CLK_MHZ cycles. During it clrLine is 10 (high voltage), clkLine and proLine are 00, and pumpEn is 1.
- R4: Exactly one cycle follows the erase step with all three lines at 00 and pumpEn at 1. CLR is therefore at zero in the cycle before PRO first goes to high voltage.
- R5: The STORE program step lasts STORE_US*CLK_MHZ cycles. During it clrLine is 00, clkLine is 01 (supply), proLine is 10 and pumpEn is 1.
- R6: pumpEn is 1 only within a STORE (erase, gap and program) and is 0 throughout a RECALL.
- R7: During RECALL all three lines are 01. supplyRamp is 0 for DN_US*CLK_MHZ ramp-down cycles and then for HOLD_US*CLK_MHZ hold cycles. It is 1 for the UP_US*CLK_MHZ ramp-up cycles that follow.
- R8: The cycle after the last phase of either sequence has done=1, busy=1, all lines at 00 and pumpEn at 0. In the next cycle done and busy are both 0.
- R9: Start edges that arrive while busy is 1 are ignored. The running sequence keeps its phase order and timing.
- R10: ramAccessEn is 1 only while nvMode is 0 and no sequence is running. While nvMode is 0, start edges are ignored.
- R11: No gate line ever carries the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nvMode | input | 1 | 1 = transfer mode, 0 = plain RAM mode |
| recallSel | input | 1 | Sequence choice sampled at the start edge: 0 STORE, 1 RECALL |
| startPulse | input | 1 | Start request, rising-edge sensitive |
| clkLine | output | 2 | Level code for the CLK gate line |
| proLine | output | 2 | Level code for the PRO gate line |
| clrLine | output | 2 | Level code for the CLR gate line |
| pumpEn | output | 1 | High-voltage pump enable |
| supplyRamp | output | 1 | Array supply control, 1 = toward supply, 0 = toward ground |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-clock end-of-sequence pulse |
| ramAccessEn | output | 1 | Ordinary RAM access allowed |

## Verification
The start edge is registered once, so the first phase shows in the cycle right after the clock edge that samples the pulse. For a STORE of S cycles per step, the erase step fills cycles 1 to S after that edge. The gap falls on cycle S+1, the program step fills S+2 to 2S+1, done falls on 2S+2 and the block is idle from 2S+3. A RECALL with ramp-down D, hold H and ramp-up U reaches done at D+H+U+1. The bench drives inputs on falling edges and counts whole cycles from the start edge. It samples on the first and last cycle of each phase, where an off-by-one error in the timing would show.

// File: rtl/nvxfer_pkg.sv
package nvxfer_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO   = 2'b00,
    LVL_SUPPLY = 2'b01,
    LVL_HIGH   = 2'b10
  } lineLvl_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_GAP   = 3'd2,
    PH_PROG  = 3'd3,
    PH_RDN   = 3'd4,
    PH_RHOLD = 3'd5,
    PH_RUP   = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  typedef struct packed {
    logic   load;
    phase_e loadPhase;
    phase_e phase;
  } seqStrobe_t;

endpackage

// File: rtl/nvxfer_ctrl.sv
module nvxfer_ctrl
  import nvxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nvMode,
  input  logic       recallSel,
  input  logic       startPulse,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       ramAccessEn
);

  phase_e phase, phaseNxt;
  logic   startPrev;
  logic   startEdge;
  logic   loadNxt;

  assign startEdge = startPulse & ~startPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      startPrev <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      startPrev <= startPulse;
    end
  end

  always_comb begin
    phaseNxt = phase;
    loadNxt  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (startEdge && nvMode) begin
          phaseNxt = recallSel ? PH_RDN : PH_ERASE;
          loadNxt  = 1'b1;
        end
      end
      PH_ERASE: if (cntZero) phaseNxt = PH_GAP;
      PH_GAP: begin
        phaseNxt = PH_PROG;
        loadNxt  = 1'b1;
      end
      PH_PROG: if (cntZero) phaseNxt = PH_DONE;
      PH_RDN: begin
        if (cntZero) begin
          phaseNxt = PH_RHOLD;
          loadNxt  = 1'b1;
        end
      end
      PH_RHOLD: begin
        if (cntZero) begin
          phaseNxt = PH_RUP;
          loadNxt  = 1'b1;
        end
      end
      PH_RUP:  if (cntZero) phaseNxt = PH_DONE;
      PH_DONE: phaseNxt = PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  assign strobe.load      = loadNxt;
  assign strobe.loadPhase = phaseNxt;
  assign strobe.phase     = phase;

  assign busy        = (phase != PH_IDLE);
  assign done        = (phase == PH_DONE);
  assign ramAccessEn = ~nvMode & (phase == PH_IDLE);

  // R8
  done_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_then_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R10
  ram_mode_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !nvMode) |=> !busy);

endmodule

// File: rtl/nvxfer_datapath.sv
module nvxfer_datapath
  import nvxfer_pkg::*;
#(
  parameter int STEP_CYC = 1250000,
  parameter int DN_CYC   = 12500,
  parameter int HOLD_CYC = 12500,
  parameter int UP_CYC   = 12500,
  localparam int MAX_A   = (STEP_CYC > DN_CYC) ? STEP_CYC : DN_CYC,
  localparam int MAX_B   = (HOLD_CYC > UP_CYC) ? HOLD_CYC : UP_CYC,
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       cntZero,
  output lineLvl_e   clkLine,
  output lineLvl_e   proLine,
  output lineLvl_e   clrLine,
  output logic       pumpEn,
  output logic       supplyRamp
);

  logic [CNT_W-1:0] remain;

  function automatic logic [CNT_W-1:0] lastIdx(phase_e p);
    case (p)
      PH_ERASE, PH_PROG: return CNT_W'(STEP_CYC - 1);
      PH_RDN:            return CNT_W'(DN_CYC - 1);
      PH_RHOLD:          return CNT_W'(HOLD_CYC - 1);
      PH_RUP:            return CNT_W'(UP_CYC - 1);
      default:           return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (strobe.load) begin
      remain <= lastIdx(strobe.loadPhase);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign cntZero = (remain == '0);

  always_comb begin
    clkLine    = LVL_ZERO;
    proLine    = LVL_ZERO;
    clrLine    = LVL_ZERO;
    pumpEn     = 1'b0;
    supplyRamp = 1'b1;
    unique case (strobe.phase)
      PH_ERASE: begin
        clrLine = LVL_HIGH;
        pumpEn  = 1'b1;
      end
      PH_GAP: pumpEn = 1'b1;
      PH_PROG: begin
        clkLine = LVL_SUPPLY;
        proLine = LVL_HIGH;
        pumpEn  = 1'b1;
      end
      PH_RDN, PH_RHOLD: begin
        clkLine    = LVL_SUPPLY;
        proLine    = LVL_SUPPLY;
        clrLine    = LVL_SUPPLY;
        supplyRamp = 1'b0;
      end
      PH_RUP: begin
        clkLine = LVL_SUPPLY;
        proLine = LVL_SUPPLY;
        clrLine = LVL_SUPPLY;
      end
      default: ;
    endcase
  end

  // R11
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkLine != 2'b11) && (proLine != 2'b11) && (clrLine != 2'b11));

  // R4
  clr_low_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(proLine == LVL_HIGH) |-> ($past(clrLine) == LVL_ZERO));

  // R6
  pump_recall_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrLine == LVL_SUPPLY) |-> !pumpEn);

  // R7
  supply_off_recall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyRamp |-> (clkLine == LVL_SUPPLY && proLine == LVL_SUPPLY));

  // R3
  count_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.loadPhase == PH_ERASE) |=> (remain == CNT_W'(STEP_CYC - 1)));

endmodule

// File: rtl/nvxfer_top.sv
module nvxfer_top
  import nvxfer_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int STORE_US = 10000,
  parameter int DN_US    = 100,
  parameter int HOLD_US  = 100,
  parameter int UP_US    = 100,
  localparam int STEP_CYC = STORE_US * CLK_MHZ,
  localparam int DN_CYC   = DN_US * CLK_MHZ,
  localparam int HOLD_CYC = HOLD_US * CLK_MHZ,
  localparam int UP_CYC   = UP_US * CLK_MHZ
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       nvMode,
  input  logic       recallSel,
  input  logic       startPulse,
  output logic [1:0] clkLine,
  output logic [1:0] proLine,
  output logic [1:0] clrLine,
  output logic       pumpEn,
  output logic       supplyRamp,
  output logic       busy,
  output logic       done,
  output logic       ramAccessEn
);

  seqStrobe_t strobe;
  logic       cntZero;
  lineLvl_e   clkLvl, proLvl, clrLvl;

  nvxfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .nvMode     (nvMode),
    .recallSel  (recallSel),
    .startPulse (startPulse),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .ramAccessEn(ramAccessEn)
  );

  nvxfer_datapath #(
    .STEP_CYC(STEP_CYC),
    .DN_CYC  (DN_CYC),
    .HOLD_CYC(HOLD_CYC),
    .UP_CYC  (UP_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntZero   (cntZero),
    .clkLine   (clkLvl),
    .proLine   (proLvl),
    .clrLine   (clrLvl),
    .pumpEn    (pumpEn),
    .supplyRamp(supplyRamp)
  );

  assign clkLine = clkLvl;
  assign proLine = proLvl;
  assign clrLine = clrLvl;

endmodule

// File: tb/nvxfer_top_tb.sv
module nvxfer_top_tb;

  localparam int CLK_MHZ = 125;
  localparam int ST_US   = 40;
  localparam int DN_US   = 8;
  localparam int HD_US   = 4;
  localparam int UP_US   = 8;
  localparam int S = ST_US * CLK_MHZ;
  localparam int D = DN_US * CLK_MHZ;
  localparam int H = HD_US * CLK_MHZ;
  localparam int U = UP_US * CLK_MHZ;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nvMode = 1'b0;
  logic recallSel = 1'b0;
  logic startPulse = 1'b0;
  logic [1:0] clkLine, proLine, clrLine;
  logic pumpEn, supplyRamp, busy, done, ramAccessEn;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvxfer_top #(
    .CLK_MHZ(CLK_MHZ), .STORE_US(ST_US), .DN_US(DN_US), .HOLD_US(HD_US), .UP_US(UP_US)
  ) u_dut (
    .clk(clk), .rstN(rstN), .nvMode(nvMode), .recallSel(recallSel),
    .startPulse(startPulse), .clkLine(clkLine), .proLine(proLine),
    .clrLine(clrLine), .pumpEn(pumpEn), .supplyRamp(supplyRamp),
    .busy(busy), .done(done), .ramAccessEn(ramAccessEn)
  );

  task automatic chk(string req, string what, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves the bench at the first falling edge after the start edge
  task automatic pulseStart();
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic chkLines(string req, int c, int p, int r, int pump);
    chk(req, "clkLine", clkLine, c);
    chk(req, "proLine", proLine, p);
    chk(req, "clrLine", clrLine, r);
    chk(req, "pumpEn", pumpEn, pump);
  endtask

  task automatic tReset();
    // R1
    chkLines("R1", 0, 0, 0, 0);
    chk("R1", "supplyRamp", supplyRamp, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
  endtask

  task automatic tStore();
    nvMode = 1'b1; recallSel = 1'b0;
    waitCyc(1);
    chk("R10", "ramAccessEn in transfer mode", ramAccessEn, 0);
    pulseStart();
    chk("R2", "busy after start", busy, 1);
    chkLines("R3", 0, 0, 2, 1);
    waitCyc(S - 1);
    chkLines("R3", 0, 0, 2, 1);
    waitCyc(1);
    chkLines("R4", 0, 0, 0, 1);
    waitCyc(1);
    chkLines("R5", 1, 2, 0, 1);
    chk("R10", "ramAccessEn during store", ramAccessEn, 0);
    waitCyc(S - 1);
    chkLines("R5", 1, 2, 0, 1);
    chk("R8", "done early", done, 0);
    waitCyc(1);
    chk("R8", "done", done, 1);
    chk("R8", "busy in done", busy, 1);
    chkLines("R6", 0, 0, 0, 0);
    waitCyc(1);
    chk("R8", "done after", done, 0);
    chk("R8", "busy after", busy, 0);
    // R11
    chk("R11", "clkLine legal", int'(clkLine != 2'b11), 1);
  endtask

  task automatic tRecall();
    nvMode = 1'b1; recallSel = 1'b1;
    pulseStart();
    chkLines("R7", 1, 1, 1, 0);
    chk("R7", "ramp down", supplyRamp, 0);
    waitCyc(D - 1);
    chk("R7", "ramp down end", supplyRamp, 0);
    waitCyc(1);
    chk("R7", "hold start", supplyRamp, 0);
    chk("R6", "pump in recall", pumpEn, 0);
    waitCyc(H - 1);
    chk("R7", "hold end", supplyRamp, 0);
    waitCyc(1);
    chk("R7", "ramp up start", supplyRamp, 1);
    chkLines("R7", 1, 1, 1, 0);
    waitCyc(U - 1);
    chk("R7", "ramp up end", supplyRamp, 1);
    chk("R8", "done early", done, 0);
    waitCyc(1);
    chk("R8", "recall done", done, 1);
    chkLines("R8", 0, 0, 0, 0);
    waitCyc(1);
    chk("R8", "recall idle", busy, 0);
    recallSel = 1'b0;
  endtask

  task automatic tBusyIgnore();
    nvMode = 1'b1; recallSel = 1'b0;
    pulseStart();                 // cycle 1
    waitCyc(9);                   // cycle 10
    recallSel = 1'b1;
    pulseStart();                 // cycle 11
    chkLines("R9", 0, 0, 2, 1);
    waitCyc(S - 11);              // cycle S
    chkLines("R9", 0, 0, 2, 1);
    waitCyc(1);                   // cycle S+1
    chkLines("R9", 0, 0, 0, 1);
    waitCyc(S + 1);               // cycle 2S+2
    chk("R9", "done timing", done, 1);
    waitCyc(1);
    chk("R9", "no restart", busy, 0);
    recallSel = 1'b0;
  endtask

  task automatic tModeGate();
    nvMode = 1'b0; recallSel = 1'b0;
    waitCyc(1);
    chk("R10", "ramAccessEn in RAM mode", ramAccessEn, 1);
    pulseStart();
    chk("R10", "start ignored busy", busy, 0);
    chkLines("R10", 0, 0, 0, 0);
    waitCyc(1);
    chk("R10", "still idle", busy, 0);
    chk("R10", "ramAccessEn kept", ramAccessEn, 1);
  endtask

  task automatic tLevelStart();
    nvMode = 1'b1; recallSel = 1'b1;
    startPulse = 1'b1;
    waitCyc(1);
    chk("R2", "level start begins", busy, 1);
    waitCyc(D + H + U);
    chk("R2", "level done", done, 1);
    waitCyc(2);
    chk("R2", "held level no restart", busy, 0);
    startPulse = 1'b0;
    recallSel = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    waitCyc(3);
    tReset();
    rstN = 1'b1;
    waitCyc(2);
    tReset();
    tModeGate();
    tStore();
    tRecall();
    tBusyIgnore();
    tLevelStart();
    waitCyc(2);
    finishRun();
  end

endmodule